// File: doc/BRIEF.md
# Shared-Memory Output-Queued Switch Element

This block is an S-by-S switch element built around one shared cell memory. Fixed-width cells arrive on S input ports, each with a valid/ready handshake and an S-bit destination mask. They leave on S output ports, each with its own valid/ready handshake. There is no crossbar. An accepted cell is written into a free slot of the shared memory. The slot number is then appended to the pointer queue of every output named in the mask. Each output reads slots back in the order they were queued, so the memory's write and read addressing does all of the switching.

Access to the memory is shared by a free-running round-robin phase counter. In phase p, only input p may write a cell and only output p may move a cell from the memory into its output register. Every port therefore gets one write turn and one read turn in each period of S cycles. Free slots are held in a pool that is itself a small memory. Any output may take any free slot, so a busy output can use space that an idle output leaves unused. A multicast cell is stored once. Its slot carries a count of the readers that remain, and the slot goes back to the pool only after the last of them has read it. When no slot is free, or when a destination queue is full, the input is held off through its ready signal, and no cell is ever dropped.

Top module: `shmem_switch`

## Requirements
- R1: Reset behaviour. While reset is held and in the first cycle after it, every output valid is low. Reset fills the slot pool with all SLOTS addresses and leaves every pointer queue empty.
- R2: Input turns. The phase is 0 in the first cycle after reset and then advances by one each cycle, returning to 0 after S-1. Only the input whose index equals the phase may see ready high, so at most one ready bit is high in any cycle. An input that has room is accepted within S cycles.
- R3: Unicast delivery. A cell whose mask has only bit k set (bit k selects output k) appears unchanged on output k and on no other output.
- R4: Ordering. Each output delivers its cells in the order the switch accepted them, including cells that came from different inputs.
- R5: Multicast. A cell whose mask has several bits set takes one slot and appears unchanged, exactly once, on every selected output. The slot is freed only after the last selected output has loaded it, and a newly written slot is never the slot being read in the same cycle.
- R6: Empty mask. A cell whose mask is all zeros is accepted in its input's turn, even when the pool is empty. It takes no slot, is never written to memory and produces no output.
- R7: Pool exhaustion. A cell with a non-zero mask is held off while the pool is empty. A slot returns to the pool when its last reader copies the cell into an output register. So with every output stalled and each input i sending only to output i, exactly SLOTS+S cells are accepted (20 with the default parameters), and all of them are delivered once the outputs resume.
- R8: Queue full. A cell is held off while any of its destination queues holds QDEPTH entries. A single stalled output therefore absorbs exactly QDEPTH+1 cells (9 by default), and the rest wait at their inputs without loss.
- R9: Output handshake. An output only loads a new cell when its register is empty or is being taken in the same cycle. While valid is high and ready is low, valid stays high and the data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | NPORTS | Per-input cell valid |
| inReady | output | NPORTS | Per-input ready; high only in that input's turn |
| inDest | input | NPORTS x NPORTS | Per-input destination mask; bit k selects output k |
| inData | input | NPORTS x CELL_W | Per-input cell payload |
| outValid | output | NPORTS | Per-output cell valid |
| outReady | input | NPORTS | Per-output consumer ready |
| outData | output | NPORTS x CELL_W | Per-output cell payload |

## Verification
The main function is exercised with a mixed vector sequence: one-hot masks to each output, repeated cells from one input to one output, cells from several inputs that converge on one output, a two-way multicast, a broadcast and an all-zero mask. A per-output model of the expected cells shows whether a cell was misrouted, duplicated, lost or reordered. Stalling a single output while two inputs feed it measures the queue-full limit apart from the pool limit. Stalling all outputs while each input feeds its own output measures the pool limit, and also shows whether slots are freed when a cell is loaded into an output register. An empty-mask cell offered while the pool is empty, and a non-empty one offered alongside it, show that the two cases are handled differently.

// File: rtl/ssw_pkg.sv
package ssw_pkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic wrCell;  // store the current phase's input cell at wrAddr
    logic rdCell;  // copy the slot at rdAddr into the current phase's output register
  } memStrobe_t;
endpackage

// File: rtl/ssw_ptr_fifo.sv
module ssw_ptr_fifo #(
  parameter int DEPTH     = 8,
  parameter int W         = 4,
  parameter bit INIT_FULL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] popData,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= INIT_FULL ? CW'(DEPTH) : '0;
      for (int i = 0; i < DEPTH; i++) store[i] <= W'(i);
    end else begin
      if (push) begin
        store[tail] <= pushData;
        tail        <= bump(tail);
      end
      if (pop) head <= bump(head);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign popData = store[head];
  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
endmodule

// File: rtl/ssw_ctrl.sv
module ssw_ctrl
  import ssw_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int SLOTS  = 16,
  parameter int QDEPTH = 8,
  localparam int PHW   = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int AW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NPORTS-1:0]              inValid,
  input  logic [NPORTS-1:0][NPORTS-1:0]  inDest,
  output logic [NPORTS-1:0]              inReady,
  input  logic [NPORTS-1:0]              outReady,
  output logic [NPORTS-1:0]              outValid,
  output memStrobe_t                     strobe,
  output logic [PHW-1:0]                 phase,
  output logic [AW-1:0]                  wrAddr,
  output logic [AW-1:0]                  rdAddr
);
  localparam int RCW = $clog2(NPORTS + 1);

  logic [NPORTS-1:0] curDest, qFull, qEmpty;
  logic [AW-1:0]     qHead [NPORTS];
  logic [AW-1:0]     freeHead;
  logic [RCW-1:0]    refCnt [SLOTS];
  logic              poolEmpty, poolFull, canTake, rdGo, relEn;

  // Round-robin turn counter shared by inputs and outputs.
  always_ff @(posedge clk) begin
    if (!rst_n)                             phase <= '0;
    else if (phase == PHW'(NPORTS - 1))     phase <= '0;
    else                                    phase <= phase + PHW'(1);
  end

  assign curDest = inDest[phase];
  assign canTake = (curDest == '0) || (!poolEmpty && ((curDest & qFull) == '0));

  always_comb begin
    for (int i = 0; i < NPORTS; i++) inReady[i] = canTake && (phase == PHW'(i));
  end

  assign strobe.wrCell = inValid[phase] && canTake && (curDest != '0);
  assign wrAddr        = freeHead;

  assign rdGo          = !qEmpty[phase] && (!outValid[phase] || outReady[phase]);
  assign strobe.rdCell = rdGo;
  assign rdAddr        = qHead[phase];
  assign relEn         = rdGo && (refCnt[rdAddr] == RCW'(1));

  ssw_ptr_fifo #(.DEPTH(SLOTS), .W(AW), .INIT_FULL(1'b1)) freePool_i (
    .clk(clk), .rst_n(rst_n),
    .push(relEn && !poolFull), .pushData(rdAddr),
    .pop(strobe.wrCell), .popData(freeHead),
    .empty(poolEmpty), .full(poolFull)
  );

  for (genvar q = 0; q < NPORTS; q++) begin : g_queue
    ssw_ptr_fifo #(.DEPTH(QDEPTH), .W(AW), .INIT_FULL(1'b0)) ptrQ_i (
      .clk(clk), .rst_n(rst_n),
      .push(strobe.wrCell && curDest[q]), .pushData(freeHead),
      .pop(rdGo && (phase == PHW'(q))), .popData(qHead[q]),
      .empty(qEmpty[q]), .full(qFull[q])
    );
  end

  // Remaining readers per slot; the written and read slots always differ.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) refCnt[i] <= '0;
    end else begin
      if (strobe.wrCell) refCnt[wrAddr] <= RCW'($countones(curDest));
      if (rdGo)          refCnt[rdAddr] <= refCnt[rdAddr] - RCW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= '0;
    end else begin
      for (int p = 0; p < NPORTS; p++) begin
        if (rdGo && (phase == PHW'(p))) outValid[p] <= 1'b1;
        else if (outReady[p])           outValid[p] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ssw_datapath.sv
module ssw_datapath
  import ssw_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int SLOTS  = 16,
  parameter int CELL_W = 256,
  localparam int PHW   = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int AW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                             clk,
  input  memStrobe_t                       strobe,
  input  logic [PHW-1:0]                   phase,
  input  logic [AW-1:0]                    wrAddr,
  input  logic [AW-1:0]                    rdAddr,
  input  logic [NPORTS-1:0][CELL_W-1:0]    inData,
  output logic [NPORTS-1:0][CELL_W-1:0]    outData
);
  logic [CELL_W-1:0] cellMem [SLOTS];

  always_ff @(posedge clk) begin
    if (strobe.wrCell) cellMem[wrAddr] <= inData[phase];
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORTS; p++) begin
      if (strobe.rdCell && (phase == PHW'(p))) outData[p] <= cellMem[rdAddr];
    end
  end
endmodule

// File: rtl/shmem_switch.sv
module shmem_switch
  import ssw_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int CELL_W = 256,
  parameter int SLOTS  = 16,
  parameter int QDEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NPORTS-1:0]                inValid,
  output logic [NPORTS-1:0]                inReady,
  input  logic [NPORTS-1:0][NPORTS-1:0]    inDest,
  input  logic [NPORTS-1:0][CELL_W-1:0]    inData,
  output logic [NPORTS-1:0]                outValid,
  input  logic [NPORTS-1:0]                outReady,
  output logic [NPORTS-1:0][CELL_W-1:0]    outData
);
  localparam int PHW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int AW  = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  memStrobe_t     strobe;
  logic [PHW-1:0] phase;
  logic [AW-1:0]  wrAddr, rdAddr;

  ssw_ctrl #(.NPORTS(NPORTS), .SLOTS(SLOTS), .QDEPTH(QDEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inDest(inDest), .inReady(inReady),
    .outReady(outReady), .outValid(outValid), .strobe(strobe), .phase(phase),
    .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  ssw_datapath #(.NPORTS(NPORTS), .SLOTS(SLOTS), .CELL_W(CELL_W)) dp_i (
    .clk(clk), .strobe(strobe), .phase(phase), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inData(inData), .outData(outData)
  );
endmodule

// File: rtl/shmem_switch_chk.sv
module shmem_switch_chk
  import ssw_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int CELL_W = 256,
  parameter int PHW    = 2,
  parameter int AW     = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NPORTS-1:0]              inValid,
  input logic [NPORTS-1:0]              inReady,
  input logic [NPORTS-1:0][NPORTS-1:0]  inDest,
  input logic [NPORTS-1:0]              outValid,
  input logic [NPORTS-1:0]              outReady,
  input logic [NPORTS-1:0][CELL_W-1:0]  outData,
  input memStrobe_t                     strobe,
  input logic [PHW-1:0]                 phase,
  input logic [AW-1:0]                  wrAddr,
  input logic [AW-1:0]                  rdAddr
);
  // R1: nothing is offered right after reset.
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (outValid == '0));

  // R2: readiness only for the input whose turn it is.
  a_r2_ready_in_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (inReady != '0) |-> (inReady == (NPORTS'(1) << phase)));

  // R3: memory is written only for an accepted cell.
  a_r3_write_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrCell |-> (inValid[phase] && inReady[phase]));

  // R6: an empty-mask cell never occupies memory.
  a_r6_empty_mask_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid[phase] && inReady[phase] && (inDest[phase] == '0)) |-> !strobe.wrCell);

  // R5: the slot being filled is never the slot being drained.
  a_r5_fresh_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrCell && strobe.rdCell) |-> (wrAddr != rdAddr));

  // R9: a load never overwrites a cell the consumer has not taken.
  a_r9_load_into_free: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.rdCell |-> (!outValid[phase] || outReady[phase]));

  for (genvar p = 0; p < NPORTS; p++) begin : g_out
    // R9: a stalled output keeps its cell.
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (outValid[p] && !outReady[p]) |=> (outValid[p] && $stable(outData[p])));
  end
endmodule

bind shmem_switch shmem_switch_chk #(
  .NPORTS(NPORTS), .CELL_W(CELL_W), .PHW(PHW), .AW(AW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady), .inDest(inDest),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .strobe(strobe), .phase(phase), .wrAddr(wrAddr), .rdAddr(rdAddr)
);

// File: tb/shmem_switch_tb_top.sv
`timescale 1ns/1ps
module shmem_switch_tb_top;
  localparam int NP = 4;
  localparam int CW = 256;
  localparam int NSLOT = 16;
  localparam int QD = 8;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic [NP-1:0]           inValid, inReady, outValid, outReady;
  logic [NP-1:0][NP-1:0]   inDest;
  logic [NP-1:0][CW-1:0]   inData, outData;

  always #4 clk = ~clk;

  shmem_switch #(.NPORTS(NP), .CELL_W(CW), .SLOTS(NSLOT), .QDEPTH(QD)) dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady), .inDest(inDest),
    .inData(inData), .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  int nChecks = 0;
  int nFails  = 0;
  int accepted;
  logic [CW-1:0] expQ [NP][128];
  int expWr [NP];
  int expRd [NP];

  // Vector fields: {src[3:0], mask[3:0], tag[7:0]}.
  localparam logic [15:0] VEC [12] = '{
    16'h0_1_01, 16'h1_2_02, 16'h2_4_03, 16'h3_8_04, 16'h0_8_05, 16'h1_F_06,
    16'h2_0_07, 16'h3_5_08, 16'h0_1_09, 16'h0_1_0A, 16'h3_1_0B, 16'h2_A_0C
  };

  function automatic logic [CW-1:0] mkData(input int tag);
    logic [31:0] w;
    w = 32'h5A00_0000 ^ (tag * 32'h0001_0203);
    return {8{w}};
  endfunction

  task automatic check(input bit ok, input string req, input logic [CW-1:0] act,
                       input logic [CW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // Offer one cell on input p for up to maxCyc cycles; record it when taken.
  task automatic trySend(input int p, input logic [NP-1:0] mask, input logic [CW-1:0] d,
                         input int maxCyc, output bit ok);
    inValid[p] = 1'b1;
    inDest[p]  = mask;
    inData[p]  = d;
    ok = 1'b0;
    for (int c = 0; c < maxCyc && !ok; c++) begin
      @(negedge clk);
      if (inReady[p]) begin
        ok = 1'b1;
        for (int q = 0; q < NP; q++)
          if (mask[q]) begin expQ[q][expWr[q]] = d; expWr[q]++; end
      end
      @(posedge clk); #1;
    end
    inValid[p] = 1'b0;
  endtask

  task automatic streamCells(input int p, input logic [NP-1:0] mask, input int attempts,
                             input int baseTag);
    bit ok;
    for (int k = 0; k < attempts; k++) begin
      trySend(p, mask, mkData(baseTag + k), 8, ok);
      if (ok) accepted++;
    end
  endtask

  task automatic checkDrained(input string req);
    for (int q = 0; q < NP; q++)
      check(expRd[q] == expWr[q], req, CW'(expRd[q]), CW'(expWr[q]));
  endtask

  // Output monitor: every delivered cell must match the model head (R3 R4 R5).
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      for (int q = 0; q < NP; q++) begin
        if (outValid[q] && outReady[q]) begin
          if (expRd[q] >= expWr[q]) begin
            check(1'b0, "R3 unexpected cell", outData[q], '0);
          end else begin
            check(outData[q] == expQ[q][expRd[q]], "R3 R4 R5 cell data/order",
                  outData[q], expQ[q][expRd[q]]);
            expRd[q]++;
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, '0);
    finishRun();
  end

  initial begin
    bit ok;
    logic [CW-1:0] held;
    for (int q = 0; q < NP; q++) begin expWr[q] = 0; expRd[q] = 0; end
    rst_n = 1'b0; inValid = '0; inDest = '0; inData = '0; outReady = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == '0, "R1 outputs idle in reset", CW'(outValid), '0);

    // R2 / R6: empty-mask cells on every input reveal the turn order.
    inValid = '1;
    @(posedge clk); #1 rst_n = 1'b1;
    for (int k = 0; k < NP; k++) begin
      @(negedge clk);
      check(inReady == NP'(1 << k), "R2 turn order", CW'(inReady), CW'(1 << k));
      check(outValid == '0, "R1 R6 no output", CW'(outValid), '0);
    end
    @(posedge clk); #1 inValid = '0;

    // Vector table: routing, multicast, empty mask and ordering.
    for (int v = 0; v < 12; v++) begin
      trySend(int'(VEC[v][15:12]), VEC[v][11:8], mkData(int'(VEC[v][7:0])), NP, ok);
      check(ok, "R2 accepted within a period", CW'(ok), CW'(1));
    end
    repeat (20) @(posedge clk);
    checkDrained("R3 R5 R6 all delivered");

    // R8: one stalled output, two inputs feeding it.
    #1 outReady = '0; accepted = 0;
    fork
      streamCells(0, 4'b0001, 14, 100);
      streamCells(1, 4'b0001, 14, 200);
    join
    check(accepted == QD + 1, "R8 queue-full limit", CW'(accepted), CW'(QD + 1));
    @(negedge clk);
    held = outData[0];
    repeat (5) @(negedge clk);
    check(outValid[0] && outData[0] == held, "R9 stalled output holds", outData[0], held);
    @(posedge clk); #1 outReady = '1;
    repeat (60) @(posedge clk);
    checkDrained("R8 no cell lost");

    // R7: all outputs stalled, each input to its own output.
    #1 outReady = '0; accepted = 0;
    fork
      streamCells(0, 4'b0001, 10, 300);
      streamCells(1, 4'b0010, 10, 400);
      streamCells(2, 4'b0100, 10, 500);
      streamCells(3, 4'b1000, 10, 600);
    join
    check(accepted == NSLOT + NP, "R7 pool limit", CW'(accepted), CW'(NSLOT + NP));
    trySend(1, 4'b0010, mkData(700), 8, ok);
    check(!ok, "R7 held off when pool empty", CW'(ok), '0);
    trySend(2, 4'b0000, mkData(701), 8, ok);
    check(ok, "R6 empty mask taken with empty pool", CW'(ok), CW'(1));
    outReady = '1;
    repeat (80) @(posedge clk);
    checkDrained("R7 no cell lost");
    finishRun();
  end
endmodule